// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block decides which operating mode a CAN controller is in: sleep (low power, off the bus), freeze (configuration, off the bus) or normal (on the bus). Software writes a small request word that holds a sleep request, a freeze request, an automatic wake-up enable and a sleep-entry interrupt enable. Software then watches the two hardware confirmation outputs to learn when a requested transition has finished. After a power-on or partial software reset the sleep request reads 1, so the controller always starts asleep.

Mode changes follow the bus. Entering freeze or sleep waits until any transmission or reception in progress has ended. Leaving freeze waits until eleven consecutive recessive bits have been counted on bit-time strobes. A dominant level on the synchronised RX line wakes the block on its own when automatic wake-up is enabled. Two write-one-to-clear flags record sleep entry and sleep exit, and either flag drives a status-change interrupt. The block also reports the real-time and last-sampled RX levels and whether a frame is being sent or received.

The state machine has six states:
- `ST_SLEEP`: sleep confirmed.
- `ST_FRZ_PEND`: waiting for idle before freeze.
- `ST_FREEZE`: freeze confirmed.
- `ST_SYNC`: freeze still confirmed while recessive bits are counted.
- `ST_NORMAL`: on the bus.
- `ST_SLP_PEND`: waiting for idle before sleep.

Its transitions are:
- SLEEP→FRZ_PEND when freeze is requested.
- SLEEP→NORMAL when neither sleep nor freeze is requested.
- FRZ_PEND→FREEZE when idle.
- FRZ_PEND→NORMAL when the freeze request is withdrawn.
- FREEZE→SYNC when freeze is released and no sleep is requested.
- FREEZE→SLP_PEND when freeze is released and sleep is requested.
- SYNC→NORMAL after 11 recessive bits.
- SYNC→FRZ_PEND or SYNC→SLP_PEND on a new request.
- NORMAL→FRZ_PEND on a freeze request, with priority.
- NORMAL→SLP_PEND on a sleep request.
- SLP_PEND→SLEEP when idle.
- SLP_PEND→FRZ_PEND on a freeze request.
- SLP_PEND→NORMAL when the sleep request is withdrawn.

Top module: `can_mode_seq`

## Requirements
- R1: After reset: `sleep_req_o`=1, `sleep_ack_o`=1, `freeze_ack_o`=0, `rx_now_o`=1, `rx_last_o`=1, both flags=0, `status_irq_o`=0, `tx_active_o`=0, `rx_active_o`=0.
- R2: `rx_pin_i` reaches `rx_now_o` through two flip-flops, so a change appears two clock edges later. `rx_last_o` copies `rx_now_o` only on a cycle with `bit_tick_i`=1.
- R3: `tx_active_o` and `rx_active_o` rise one cycle after their start strobe and fall one cycle after their busy input is low.
- R4: A freeze request confirms (`freeze_ack_o`=1) only once neither `tx_active_o` nor `rx_active_o` is set.
- R5: Freeze outranks sleep. When leaving sleep for freeze, `sleep_ack_o` falls at least one cycle before `freeze_ack_o` rises, and the two acks are never 1 together.
- R6: On release of freeze, `freeze_ack_o` stays 1 until 11 consecutive recessive samples are taken on `bit_tick_i`. A dominant sample restarts that count from zero.
- R7: While asleep with automatic wake-up enabled, a dominant `rx_now_o` clears `sleep_req_o` in hardware and `sleep_ack_o` then falls. With wake-up disabled the block stays asleep.
- R8: A sleep request from normal mode confirms only once both activity outputs are clear.
- R9: `enter_flag_o` sets when `sleep_ack_o` rises, but only if the sleep-entry interrupt enable is 1. It clears on `flag_clr_i[0]`=1 or when `sleep_ack_o` falls.
- R10: `exit_flag_o` sets when `sleep_ack_o` falls, or when `rx_now_o` is dominant while asleep. It clears on `flag_clr_i[1]`=1.
- R11: `status_irq_o` is 1 exactly when either flag is set.
- R12: A one-cycle `soft_rst_i` pulse returns the block to the R1 state, except for the RX levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Partial software reset pulse |
| cfg_wr_i | input | 1 | Load the four request bits below |
| cfg_sleep_i | input | 1 | Sleep request value |
| cfg_freeze_i | input | 1 | Freeze request value |
| cfg_autowake_i | input | 1 | Automatic wake-up enable value |
| cfg_enter_ie_i | input | 1 | Sleep-entry interrupt enable value |
| flag_clr_i | input | 2 | Write-one-to-clear: bit 0 entry flag, bit 1 exit flag |
| bit_tick_i | input | 1 | One-cycle strobe per CAN bit time |
| rx_pin_i | input | 1 | Raw CAN RX pin (1 = recessive) |
| tx_start_i | input | 1 | Transmission start strobe |
| tx_busy_i | input | 1 | Transmitter busy |
| rx_start_i | input | 1 | Reception start strobe |
| rx_busy_i | input | 1 | Receiver busy |
| sleep_req_o | output | 1 | Current sleep request bit |
| sleep_ack_o | output | 1 | Sleep confirmed |
| freeze_ack_o | output | 1 | Freeze confirmed |
| rx_now_o | output | 1 | Synchronised real-time RX level |
| rx_last_o | output | 1 | RX level at the last bit strobe |
| tx_active_o | output | 1 | Transmission in progress |
| rx_active_o | output | 1 | Reception in progress |
| enter_flag_o | output | 1 | Sleep-entered flag |
| exit_flag_o | output | 1 | Sleep-left / wake-up flag |
| status_irq_o | output | 1 | Status-change interrupt |

## Verification
The bench first holds a transmission open across a freeze request and a reception open across a sleep request. A sequencer that ignored activity would confirm the mode in the middle of a frame. It then sends ten recessive bits, one dominant bit and ten more recessive bits during freeze release. A counter that did not restart, or that stopped at the wrong count, would drop `freeze_ack_o` too early or never. The exit from sleep into freeze is watched cycle by cycle, which catches a design that raises both acks together or lets the sleep ack linger. The flag tests cover the masked entry flag and the clear of the entry flag when sleep ends. They also check that a dominant RX level without auto-wake sets the exit flag but leaves the block asleep.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP    = 3'd0,
        ST_FRZ_PEND = 3'd1,
        ST_FREEZE   = 3'd2,
        ST_SYNC     = 3'd3,
        ST_NORMAL   = 3'd4,
        ST_SLP_PEND = 3'd5
    } mode_state_e;

    localparam int unsigned ACT_CH = 2;  // index 0 transmit, 1 receive

endpackage

// File: rtl/can_rx_sync.sv
module can_rx_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    input  logic tick_i,
    output logic now_o,
    output logic last_o
);
    logic [SYNC_STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i};
        end
    end

    assign now_o = chain_q[SYNC_STAGES-1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            last_o <= 1'b1;
        end else if (tick_i) begin
            last_o <= now_o;
        end
    end

    // R2
    last_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(last_o));

endmodule

// File: rtl/can_rec_counter.sv
module can_rec_counter #(
    parameter int unsigned REC_BITS = 11
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic soft_rst_i,
    input  logic en_i,
    input  logic tick_i,
    input  logic rx_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(REC_BITS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(REC_BITS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (soft_rst_i || !en_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (!rx_i) begin
                cnt_q <= '0;
            end else if (cnt_q != LIMIT) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done_o = (cnt_q == LIMIT);

    // R6
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LIMIT);

    // R6
    cnt_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (cnt_q == '0));

endmodule

// File: rtl/can_act_track.sv
module can_act_track (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic soft_rst_i,
    input  logic start_i,
    input  logic busy_i,
    output logic active_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            active_o <= 1'b0;
        end else if (soft_rst_i) begin
            active_o <= 1'b0;
        end else begin
            active_o <= start_i | (active_o & busy_i);
        end
    end

    // R3
    act_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !soft_rst_i) |=> active_o);

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic soft_rst_i,
    input  logic sleep_req_i,
    input  logic freeze_req_i,
    input  logic idle_i,
    input  logic rec_done_i,
    output logic sleep_ack_o,
    output logic freeze_ack_o,
    output logic sync_en_o
);
    mode_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLEEP: begin
                if (freeze_req_i)          state_d = ST_FRZ_PEND;
                else if (!sleep_req_i)     state_d = ST_NORMAL;
            end
            ST_FRZ_PEND: begin
                if (!freeze_req_i)         state_d = ST_NORMAL;
                else if (idle_i)           state_d = ST_FREEZE;
            end
            ST_FREEZE: begin
                if (!freeze_req_i)         state_d = sleep_req_i ? ST_SLP_PEND : ST_SYNC;
            end
            ST_SYNC: begin
                if (freeze_req_i)          state_d = ST_FRZ_PEND;
                else if (sleep_req_i)      state_d = ST_SLP_PEND;
                else if (rec_done_i)       state_d = ST_NORMAL;
            end
            ST_NORMAL: begin
                if (freeze_req_i)          state_d = ST_FRZ_PEND;
                else if (sleep_req_i)      state_d = ST_SLP_PEND;
            end
            ST_SLP_PEND: begin
                if (freeze_req_i)          state_d = ST_FRZ_PEND;
                else if (!sleep_req_i)     state_d = ST_NORMAL;
                else if (idle_i)           state_d = ST_SLEEP;
            end
            default:                       state_d = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_SLEEP;
        end else if (soft_rst_i) begin
            state_q <= ST_SLEEP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        sleep_ack_o  = 1'b0;
        freeze_ack_o = 1'b0;
        sync_en_o    = 1'b0;
        unique case (state_q)
            ST_SLEEP:    sleep_ack_o  = 1'b1;
            ST_FREEZE:   freeze_ack_o = 1'b1;
            ST_SYNC: begin
                freeze_ack_o = 1'b1;
                sync_en_o    = 1'b1;
            end
            default: begin
                sleep_ack_o  = 1'b0;
                freeze_ack_o = 1'b0;
            end
        endcase
    end

    // R5
    no_dual_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sleep_ack_o && freeze_ack_o));

    // R5
    sleep_to_freeze_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(sleep_ack_o) && !soft_rst_i) |-> !freeze_ack_o);

endmodule

// File: rtl/can_flag_unit.sv
module can_flag_unit (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       soft_rst_i,
    input  logic       sleep_ack_i,
    input  logic       enter_ie_i,
    input  logic       rx_now_i,
    input  logic [1:0] clr_i,
    output logic       enter_flag_o,
    output logic       exit_flag_o
);
    logic ack_prev_q;
    logic enter_evt, exit_evt, wake_evt;

    assign enter_evt = sleep_ack_i & ~ack_prev_q;
    assign exit_evt  = ~sleep_ack_i & ack_prev_q;
    assign wake_evt  = sleep_ack_i & ~rx_now_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ack_prev_q   <= 1'b1;
            enter_flag_o <= 1'b0;
            exit_flag_o  <= 1'b0;
        end else if (soft_rst_i) begin
            ack_prev_q   <= 1'b1;
            enter_flag_o <= 1'b0;
            exit_flag_o  <= 1'b0;
        end else begin
            ack_prev_q <= sleep_ack_i;
            if (enter_evt && enter_ie_i)      enter_flag_o <= 1'b1;
            else if (clr_i[0] || exit_evt)    enter_flag_o <= 1'b0;
            if (exit_evt || wake_evt)         exit_flag_o  <= 1'b1;
            else if (clr_i[1])                exit_flag_o  <= 1'b0;
        end
    end

    // R9
    enter_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(enter_flag_o) |-> $past(sleep_ack_i && enter_ie_i));

    // R10
    exit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(exit_flag_o) |-> $past(sleep_ack_i || ack_prev_q));

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int unsigned REC_BITS    = 11,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       soft_rst_i,
    input  logic       cfg_wr_i,
    input  logic       cfg_sleep_i,
    input  logic       cfg_freeze_i,
    input  logic       cfg_autowake_i,
    input  logic       cfg_enter_ie_i,
    input  logic [1:0] flag_clr_i,
    input  logic       bit_tick_i,
    input  logic       rx_pin_i,
    input  logic       tx_start_i,
    input  logic       tx_busy_i,
    input  logic       rx_start_i,
    input  logic       rx_busy_i,
    output logic       sleep_req_o,
    output logic       sleep_ack_o,
    output logic       freeze_ack_o,
    output logic       rx_now_o,
    output logic       rx_last_o,
    output logic       tx_active_o,
    output logic       rx_active_o,
    output logic       enter_flag_o,
    output logic       exit_flag_o,
    output logic       status_irq_o
);
    logic freeze_req_q, autowake_q, enter_ie_q;
    logic hw_wake, idle, rec_done, sync_en;
    logic [ACT_CH-1:0] act_start, act_busy, act_flag;

    // request word; the sleep bit comes up set
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sleep_req_o  <= 1'b1;
            freeze_req_q <= 1'b0;
            autowake_q   <= 1'b0;
            enter_ie_q   <= 1'b0;
        end else if (soft_rst_i) begin
            sleep_req_o  <= 1'b1;
            freeze_req_q <= 1'b0;
            autowake_q   <= 1'b0;
            enter_ie_q   <= 1'b0;
        end else if (cfg_wr_i) begin
            sleep_req_o  <= cfg_sleep_i;
            freeze_req_q <= cfg_freeze_i;
            autowake_q   <= cfg_autowake_i;
            enter_ie_q   <= cfg_enter_ie_i;
        end else if (hw_wake) begin
            sleep_req_o  <= 1'b0;
        end
    end

    assign hw_wake = sleep_ack_o & autowake_q & ~rx_now_o;

    can_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) rx_sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (rx_pin_i),
        .tick_i (bit_tick_i),
        .now_o  (rx_now_o),
        .last_o (rx_last_o)
    );

    assign act_start = {rx_start_i, tx_start_i};
    assign act_busy  = {rx_busy_i,  tx_busy_i};

    for (genvar g = 0; g < ACT_CH; g++) begin : g_act
        can_act_track act_i (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .soft_rst_i (soft_rst_i),
            .start_i    (act_start[g]),
            .busy_i     (act_busy[g]),
            .active_o   (act_flag[g])
        );
    end

    assign tx_active_o = act_flag[0];
    assign rx_active_o = act_flag[1];
    assign idle        = ~|act_flag;

    can_rec_counter #(.REC_BITS(REC_BITS)) rec_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_rst_i (soft_rst_i),
        .en_i       (sync_en),
        .tick_i     (bit_tick_i),
        .rx_i       (rx_now_o),
        .done_o     (rec_done)
    );

    can_mode_fsm fsm_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .soft_rst_i   (soft_rst_i),
        .sleep_req_i  (sleep_req_o),
        .freeze_req_i (freeze_req_q),
        .idle_i       (idle),
        .rec_done_i   (rec_done),
        .sleep_ack_o  (sleep_ack_o),
        .freeze_ack_o (freeze_ack_o),
        .sync_en_o    (sync_en)
    );

    can_flag_unit flag_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .soft_rst_i   (soft_rst_i),
        .sleep_ack_i  (sleep_ack_o),
        .enter_ie_i   (enter_ie_q),
        .rx_now_i     (rx_now_o),
        .clr_i        (flag_clr_i),
        .enter_flag_o (enter_flag_o),
        .exit_flag_o  (exit_flag_o)
    );

    assign status_irq_o = enter_flag_o | exit_flag_o;

    // R4
    freeze_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(freeze_ack_o) |-> $past(!tx_active_o && !rx_active_o));

    // R8
    sleep_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(sleep_ack_o) && !$past(soft_rst_i)) |-> $past(!tx_active_o && !rx_active_o));

    // R7
    wake_clears_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_wake && !cfg_wr_i && !soft_rst_i) |=> !sleep_req_o);

endmodule

// File: tb/can_mode_seq_tb_top.sv
`timescale 1ns/1ps
module can_mode_seq_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic cfg_wr = 1'b0, cfg_sleep = 1'b0, cfg_freeze = 1'b0, cfg_aw = 1'b0, cfg_ie = 1'b0;
    logic [1:0] clr = 2'b00;
    logic tick = 1'b0, rx_pin = 1'b1;
    logic tx_start = 1'b0, tx_busy = 1'b0, rx_start = 1'b0, rx_busy = 1'b0;
    logic sleep_req, sleep_ack, freeze_ack, rx_now, rx_last;
    logic tx_act, rx_act, enter_flag, exit_flag, irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    can_mode_seq dut_i (
        .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
        .cfg_wr_i(cfg_wr), .cfg_sleep_i(cfg_sleep), .cfg_freeze_i(cfg_freeze),
        .cfg_autowake_i(cfg_aw), .cfg_enter_ie_i(cfg_ie), .flag_clr_i(clr),
        .bit_tick_i(tick), .rx_pin_i(rx_pin),
        .tx_start_i(tx_start), .tx_busy_i(tx_busy),
        .rx_start_i(rx_start), .rx_busy_i(rx_busy),
        .sleep_req_o(sleep_req), .sleep_ack_o(sleep_ack), .freeze_ack_o(freeze_ack),
        .rx_now_o(rx_now), .rx_last_o(rx_last),
        .tx_active_o(tx_act), .rx_active_o(rx_act),
        .enter_flag_o(enter_flag), .exit_flag_o(exit_flag), .status_irq_o(irq)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic s, input logic f, input logic aw, input logic ie);
        cfg_wr = 1'b1; cfg_sleep = s; cfg_freeze = f; cfg_aw = aw; cfg_ie = ie;
        step(1);
        cfg_wr = 1'b0;
    endtask

    task automatic clear_flags(input logic [1:0] m);
        clr = m;
        step(1);
        clr = 2'b00;
    endtask

    task automatic bit_sample(input logic lvl);
        rx_pin = lvl;
        step(3);
        tick = 1'b1;
        step(1);
        tick = 1'b0;
        rx_pin = 1'b1;
        step(3);
    endtask

    task automatic join_bus();
        wr_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++) bit_sample(1'b1);
        step(2);
    endtask

    task automatic t_reset();
        step(1);
        chk("R1", "sleep_req", sleep_req, 1'b1);
        chk("R1", "sleep_ack", sleep_ack, 1'b1);
        chk("R1", "freeze_ack", freeze_ack, 1'b0);
        chk("R1", "rx_now", rx_now, 1'b1);
        chk("R1", "rx_last", rx_last, 1'b1);
        chk("R1", "flags/irq", enter_flag | exit_flag | irq, 1'b0);
        chk("R1", "activity", tx_act | rx_act, 1'b0);
    endtask

    task automatic t_rx_path();
        rx_pin = 1'b0;
        step(1);
        chk("R2", "rx_now after 1 edge", rx_now, 1'b1);
        step(1);
        chk("R2", "rx_now after 2 edges", rx_now, 1'b0);
        step(2);
        chk("R2", "rx_last without tick", rx_last, 1'b1);
        chk("R10", "exit flag on dominant while asleep", exit_flag, 1'b1);
        chk("R7", "no wake with autowake off", sleep_ack, 1'b1);
        tick = 1'b1;
        step(1);
        tick = 1'b0;
        chk("R2", "rx_last after tick", rx_last, 1'b0);
        rx_pin = 1'b1;
        step(4);
        chk("R2", "rx_last holds", rx_last, 1'b0);
        clear_flags(2'b11);
        chk("R10", "exit flag cleared", exit_flag, 1'b0);
    endtask

    task automatic t_freeze_join();
        wr_cfg(1'b0, 1'b1, 1'b0, 1'b0);
        step(3);
        chk("R5", "freeze from sleep", freeze_ack, 1'b1);
        chk("R5", "sleep ack gone", sleep_ack, 1'b0);
        wr_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) bit_sample(1'b1);
        chk("R6", "held after 10 recessive", freeze_ack, 1'b1);
        bit_sample(1'b0);
        for (int i = 0; i < 10; i++) bit_sample(1'b1);
        chk("R6", "restart after dominant", freeze_ack, 1'b1);
        bit_sample(1'b1);
        chk("R6", "released after 11 recessive", freeze_ack, 1'b0);
    endtask

    task automatic t_freeze_gate();
        tx_busy = 1'b1; tx_start = 1'b1;
        step(1);
        tx_start = 1'b0;
        chk("R3", "tx_active rises", tx_act, 1'b1);
        wr_cfg(1'b0, 1'b1, 1'b0, 1'b0);
        step(5);
        chk("R4", "freeze held off by tx", freeze_ack, 1'b0);
        tx_busy = 1'b0;
        step(1);
        chk("R3", "tx_active falls", tx_act, 1'b0);
        step(2);
        chk("R4", "freeze after idle", freeze_ack, 1'b1);
        rx_busy = 1'b1; rx_start = 1'b1;
        step(1);
        rx_start = 1'b0;
        chk("R3", "rx_active rises", rx_act, 1'b1);
        rx_busy = 1'b0;
        step(1);
        chk("R3", "rx_active falls", rx_act, 1'b0);
        join_bus();
        chk("R6", "back on bus", freeze_ack | sleep_ack, 1'b0);
    endtask

    task automatic t_sleep_gate();
        rx_busy = 1'b1; rx_start = 1'b1;
        step(1);
        rx_start = 1'b0;
        wr_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        step(5);
        chk("R8", "sleep held off by rx", sleep_ack, 1'b0);
        rx_busy = 1'b0;
        step(4);
        chk("R8", "sleep after idle", sleep_ack, 1'b1);
        chk("R9", "entry flag masked", enter_flag, 1'b0);
    endtask

    task automatic t_priority();
        int fall_at = -1;
        int rise_at = -1;
        logic both = 1'b0;
        wr_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        step(3);
        clear_flags(2'b11);
        wr_cfg(1'b1, 1'b0, 1'b0, 1'b1);
        step(4);
        chk("R9", "entry flag set", enter_flag, 1'b1);
        chk("R11", "irq from entry flag", irq, 1'b1);
        cfg_wr = 1'b1; cfg_sleep = 1'b1; cfg_freeze = 1'b1; cfg_aw = 1'b0; cfg_ie = 1'b1;
        for (int c = 0; c < 8; c++) begin
            step(1);
            cfg_wr = 1'b0;
            if (sleep_ack && freeze_ack) both = 1'b1;
            if (!sleep_ack && fall_at < 0) fall_at = c;
            if (freeze_ack && rise_at < 0) rise_at = c;
        end
        chk("R5", "acks never together", both, 1'b0);
        chk("R5", "sleep falls before freeze rises",
            (fall_at >= 0) && (rise_at > fall_at), 1'b1);
        chk("R9", "entry flag cleared by sleep exit", enter_flag, 1'b0);
        chk("R10", "exit flag on sleep exit", exit_flag, 1'b1);
        clear_flags(2'b10);
        chk("R10", "exit flag write-one-clear", exit_flag, 1'b0);
        chk("R11", "irq drops", irq, 1'b0);
        join_bus();
        wr_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        step(4);
        chk("R5", "freeze wins from normal", freeze_ack, 1'b1);
        chk("R5", "no sleep from normal", sleep_ack, 1'b0);
    endtask

    task automatic t_entry_clear();
        wr_cfg(1'b1, 1'b0, 1'b0, 1'b1);
        step(4);
        chk("R9", "entry flag from freeze to sleep", enter_flag, 1'b1);
        clear_flags(2'b01);
        chk("R9", "entry flag write-one-clear", enter_flag, 1'b0);
        chk("R11", "irq clear", irq, exit_flag);
    endtask

    task automatic t_autowake();
        clear_flags(2'b11);
        wr_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        rx_pin = 1'b0;
        step(6);
        chk("R7", "asleep without autowake", sleep_ack, 1'b1);
        chk("R7", "request kept", sleep_req, 1'b1);
        chk("R10", "wake condition flag", exit_flag, 1'b1);
        rx_pin = 1'b1;
        step(3);
        clear_flags(2'b10);
        chk("R10", "flag cleared", exit_flag, 1'b0);
        wr_cfg(1'b1, 1'b0, 1'b1, 1'b0);
        rx_pin = 1'b0;
        step(6);
        chk("R7", "hw clears request", sleep_req, 1'b0);
        chk("R7", "woke up", sleep_ack, 1'b0);
        rx_pin = 1'b1;
        step(3);
    endtask

    task automatic t_soft_reset();
        wr_cfg(1'b0, 1'b1, 1'b0, 1'b0);
        step(4);
        chk("R12", "in freeze before soft reset", freeze_ack, 1'b1);
        soft_rst = 1'b1;
        step(1);
        soft_rst = 1'b0;
        chk("R12", "sleep_req forced", sleep_req, 1'b1);
        chk("R12", "sleep_ack", sleep_ack, 1'b1);
        chk("R12", "freeze_ack", freeze_ack, 1'b0);
        chk("R12", "flags", enter_flag | exit_flag | irq, 1'b0);
    endtask

    initial begin
        #500000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_rx_path();
        t_freeze_join();
        t_freeze_gate();
        t_sleep_gate();
        t_priority();
        t_entry_clear();
        t_autowake();
        t_soft_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule